// File: doc/BRIEF.md
# Compressed Branch Address Reconstructor

This block turns a byte-wide stream of compressed branch-target packets back into full 32-bit addresses. Each packet carries seven address bits plus a continuation flag. A sequence of one to five packets updates a retained address register. Short sequences refresh only the low-order groups they carry, and the upper bits come from the previous result. Only the five-packet form carries the top nibble and a 3-bit reason code.

The block also tracks whether the reconstructed address can be trusted. Until a complete five-packet address has arrived since the last trace start, any address it produces is partly made up of zeros, and the known flag stays low. The input and the result are both valid/ready streams. A result is held until the consumer accepts it. While a result is pending and not accepted, the input is stalled. A start-of-trace pulse clears the retained state and discards any partial sequence.

Top module: `branch_addr_rebuild`

## Requirements
- R1: A five-packet sequence builds the address from packet payloads in arrival order: bits [6:0] of packets 1 to 4 give address [6:0], [13:7], [20:14] and [27:21], and bits [3:0] of packet 5 give address [31:28].
- R2: Packet bit 7 set means another packet follows. Bit 7 clear ends the sequence. A sequence may end after any of the first five packets.
- R3: A sequence of k<5 packets replaces only the k lowest 7-bit groups of the retained address. All other bits keep their previous values.
- R4: A five-packet sequence reports bits [6:4] of its fifth packet on `res_reason` with `res_reason_vld` high. Shorter sequences report `res_reason_vld` low and `res_reason` zero.
- R5: `res_known` is low after reset or start-of-trace until a five-packet sequence completes. After that it stays high for later partial sequences.
- R6: `trace_start` clears the retained address to zero, clears the known flag and any pending result, and discards the partial sequence and any byte offered in the same cycle.
- R7: `res_valid` rises in the cycle after the final packet of a sequence is accepted.
- R8: While `res_valid` is high and `res_ready` is low, the result holds stable and `pkt_ready` is low, so offered bytes are not taken.
- R9: A fifth packet with bit 7 set is a protocol error. `proto_err` pulses for one cycle in the following cycle, no result is produced, the retained address is untouched, and the next packet starts a new sequence.
- R10: After reset all outputs are zero except `pkt_ready`, which is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| trace_start | input | 1 | Start-of-trace pulse; clears retained state |
| pkt_valid | input | 1 | Input byte valid |
| pkt_ready | output | 1 | Input byte accepted when high together with pkt_valid |
| pkt_data | input | 8 | Packet: [6:0] payload, [7] continuation |
| res_valid | output | 1 | Result strobe, held until accepted |
| res_ready | input | 1 | Consumer accepts the result |
| res_addr | output | 32 | Reconstructed address |
| res_reason | output | 3 | Reason code from a five-packet sequence |
| res_reason_vld | output | 1 | Result came from a five-packet sequence |
| res_known | output | 1 | A full address has been seen since trace start |
| proto_err | output | 1 | One-cycle pulse on an over-long sequence |

## Verification
The bench walks a chain of sequences of every length, each building on the address left by the one before. A design that merged the wrong groups, or cleared the upper bits on a short sequence, would produce the wrong address at once. A byte offered under back-pressure is sent with its continuation bit set. If the block took it, the next packet would land in the second group and show up in the address. Start-of-trace is hit both with a byte in the same cycle and in the middle of a sequence; a design that kept the partial state would build the next address from stale groups. The over-long sequence test then sends a single packet. A design that failed to resynchronize, or that let the aborted groups leak into the retained address, would report the wrong value or a spurious result.

// File: rtl/bar_pkg.sv
package bar_pkg;
  localparam int unsigned BAR_ADDR_W   = 32;
  localparam int unsigned BAR_GROUP_W  = 7;
  localparam int unsigned BAR_GROUPS   = 5;
  localparam int unsigned BAR_REASON_W = 3;
endpackage

// File: rtl/bar_collect.sv
// Gathers packet payloads of one sequence and flags its end or an overrun.
module bar_collect #(
  parameter int unsigned GROUP_W = bar_pkg::BAR_GROUP_W,
  parameter int unsigned GROUPS  = bar_pkg::BAR_GROUPS,
  localparam int unsigned CW     = $clog2(GROUPS),
  localparam int unsigned NW     = $clog2(GROUPS + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      flush,
  input  logic                      take,
  input  logic [GROUP_W:0]          data,
  output logic                      seq_done,
  output logic                      seq_err,
  output logic [NW-1:0]             seq_len,
  output logic [GROUPS*GROUP_W-1:0] seq_bits
);
  logic [CW-1:0]      cnt_q;
  logic [GROUP_W-1:0] held_q [GROUPS-1];
  logic               more;
  logic               at_last;
  logic               use_byte;

  assign more     = data[GROUP_W];
  assign at_last  = (cnt_q == CW'(GROUPS - 1));
  assign use_byte = take && !flush;
  assign seq_done = use_byte && !more;
  assign seq_err  = use_byte && more && at_last;
  assign seq_len  = NW'(cnt_q) + NW'(1);

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      cnt_q <= '0;
    end else if (use_byte) begin
      cnt_q <= (more && !at_last) ? cnt_q + CW'(1) : '0;
    end
  end

  for (genvar g = 0; g < GROUPS - 1; g++) begin : g_hold
    always_ff @(posedge clk) begin
      if (rst) begin
        held_q[g] <= '0;
      end else if (use_byte && more && cnt_q == CW'(g)) begin
        held_q[g] <= data[GROUP_W-1:0];
      end
    end
    assign seq_bits[g*GROUP_W +: GROUP_W] =
      (CW'(g) < cnt_q)  ? held_q[g] :
      (cnt_q == CW'(g)) ? data[GROUP_W-1:0] : '0;
  end

  assign seq_bits[(GROUPS-1)*GROUP_W +: GROUP_W] = at_last ? data[GROUP_W-1:0] : '0;
endmodule

// File: rtl/bar_merge.sv
// Merges the received groups over the retained address.
module bar_merge #(
  parameter int unsigned ADDR_W   = bar_pkg::BAR_ADDR_W,
  parameter int unsigned GROUP_W  = bar_pkg::BAR_GROUP_W,
  parameter int unsigned GROUPS   = bar_pkg::BAR_GROUPS,
  parameter int unsigned REASON_W = bar_pkg::BAR_REASON_W,
  localparam int unsigned NW      = $clog2(GROUPS + 1),
  localparam int unsigned LAST_LO = (GROUPS - 1) * GROUP_W,
  localparam int unsigned LAST_W  = ADDR_W - LAST_LO
) (
  input  logic [ADDR_W-1:0]         old_addr,
  input  logic [GROUPS*GROUP_W-1:0] seq_bits,
  input  logic [NW-1:0]             seq_len,
  output logic [ADDR_W-1:0]         new_addr,
  output logic [REASON_W-1:0]       reason,
  output logic                      full
);
  assign full = (seq_len == NW'(GROUPS));

  for (genvar g = 0; g < GROUPS - 1; g++) begin : g_low
    assign new_addr[g*GROUP_W +: GROUP_W] =
      (seq_len > NW'(g)) ? seq_bits[g*GROUP_W +: GROUP_W] : old_addr[g*GROUP_W +: GROUP_W];
  end

  assign new_addr[LAST_LO +: LAST_W] = full ? seq_bits[LAST_LO +: LAST_W] : old_addr[LAST_LO +: LAST_W];
  assign reason = full ? seq_bits[LAST_LO + LAST_W +: REASON_W] : '0;
endmodule

// File: rtl/bar_out_stage.sv
// Retained address, trust flag and the held result register.
module bar_out_stage #(
  parameter int unsigned ADDR_W   = bar_pkg::BAR_ADDR_W,
  parameter int unsigned REASON_W = bar_pkg::BAR_REASON_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                flush,
  input  logic                load,
  input  logic                err_in,
  input  logic                full,
  input  logic [ADDR_W-1:0]   new_addr,
  input  logic [REASON_W-1:0] reason,
  input  logic                res_ready,
  output logic [ADDR_W-1:0]   kept_addr,
  output logic                res_valid,
  output logic [ADDR_W-1:0]   res_addr,
  output logic [REASON_W-1:0] res_reason,
  output logic                res_reason_vld,
  output logic                res_known,
  output logic                proto_err
);
  logic known_q;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      kept_addr      <= '0;
      known_q        <= 1'b0;
      res_valid      <= 1'b0;
      res_addr       <= '0;
      res_reason     <= '0;
      res_reason_vld <= 1'b0;
      res_known      <= 1'b0;
      proto_err      <= 1'b0;
    end else begin
      proto_err <= err_in;
      if (load) begin
        kept_addr      <= new_addr;
        known_q        <= known_q || full;
        res_valid      <= 1'b1;
        res_addr       <= new_addr;
        res_reason     <= reason;
        res_reason_vld <= full;
        res_known      <= known_q || full;
      end else if (res_ready) begin
        res_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/branch_addr_rebuild.sv
module branch_addr_rebuild #(
  parameter int unsigned ADDR_W   = bar_pkg::BAR_ADDR_W,
  parameter int unsigned GROUP_W  = bar_pkg::BAR_GROUP_W,
  parameter int unsigned GROUPS   = bar_pkg::BAR_GROUPS,
  parameter int unsigned REASON_W = bar_pkg::BAR_REASON_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                trace_start,
  input  logic                pkt_valid,
  output logic                pkt_ready,
  input  logic [GROUP_W:0]    pkt_data,
  output logic                res_valid,
  input  logic                res_ready,
  output logic [ADDR_W-1:0]   res_addr,
  output logic [REASON_W-1:0] res_reason,
  output logic                res_reason_vld,
  output logic                res_known,
  output logic                proto_err
);
  localparam int unsigned NW = $clog2(GROUPS + 1);

  logic                      seq_done;
  logic                      seq_err;
  logic [NW-1:0]             seq_len;
  logic [GROUPS*GROUP_W-1:0] seq_bits;
  logic [ADDR_W-1:0]         kept_addr;
  logic [ADDR_W-1:0]         new_addr;
  logic [REASON_W-1:0]       reason;
  logic                      full;

  assign pkt_ready = !res_valid || res_ready;

  bar_collect #(.GROUP_W(GROUP_W), .GROUPS(GROUPS)) collect_i (
    .clk(clk), .rst(rst), .flush(trace_start),
    .take(pkt_valid && pkt_ready), .data(pkt_data),
    .seq_done(seq_done), .seq_err(seq_err),
    .seq_len(seq_len), .seq_bits(seq_bits)
  );

  bar_merge #(.ADDR_W(ADDR_W), .GROUP_W(GROUP_W), .GROUPS(GROUPS), .REASON_W(REASON_W)) merge_i (
    .old_addr(kept_addr), .seq_bits(seq_bits), .seq_len(seq_len),
    .new_addr(new_addr), .reason(reason), .full(full)
  );

  bar_out_stage #(.ADDR_W(ADDR_W), .REASON_W(REASON_W)) out_i (
    .clk(clk), .rst(rst), .flush(trace_start),
    .load(seq_done), .err_in(seq_err), .full(full),
    .new_addr(new_addr), .reason(reason), .res_ready(res_ready),
    .kept_addr(kept_addr), .res_valid(res_valid), .res_addr(res_addr),
    .res_reason(res_reason), .res_reason_vld(res_reason_vld),
    .res_known(res_known), .proto_err(proto_err)
  );
endmodule

// File: rtl/branch_addr_rebuild_chk.sv
module branch_addr_rebuild_chk #(
  parameter int unsigned ADDR_W   = 32,
  parameter int unsigned GROUP_W  = 7,
  parameter int unsigned REASON_W = 3
) (
  input logic                clk,
  input logic                rst,
  input logic                trace_start,
  input logic                pkt_valid,
  input logic                pkt_ready,
  input logic [GROUP_W:0]    pkt_data,
  input logic                res_valid,
  input logic                res_ready,
  input logic [ADDR_W-1:0]   res_addr,
  input logic [REASON_W-1:0] res_reason,
  input logic                res_reason_vld,
  input logic                res_known,
  input logic                proto_err
);
  p_strobe_after_end_r7: assert property (@(posedge clk) disable iff (rst)
    (pkt_valid && pkt_ready && !trace_start && !pkt_data[GROUP_W]) |=> res_valid);

  p_hold_stalled_r8: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready && !trace_start) |=> (res_valid && $stable(res_addr)));

  p_known_needs_full_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(res_known) |-> (res_valid && res_reason_vld));

  p_reason_zero_short_r4: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_reason_vld) |-> (res_reason == '0));

  p_start_clears_r6: assert property (@(posedge clk) disable iff (rst)
    trace_start |=> (!res_valid && !res_known));

  p_err_single_r9: assert property (@(posedge clk) disable iff (rst)
    proto_err |=> !proto_err);

  p_err_no_result_r9: assert property (@(posedge clk) disable iff (rst)
    proto_err |-> !res_valid);
endmodule

bind branch_addr_rebuild branch_addr_rebuild_chk #(
  .ADDR_W(ADDR_W), .GROUP_W(GROUP_W), .REASON_W(REASON_W)
) chk_i (
  .clk(clk), .rst(rst), .trace_start(trace_start),
  .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_data(pkt_data),
  .res_valid(res_valid), .res_ready(res_ready), .res_addr(res_addr),
  .res_reason(res_reason), .res_reason_vld(res_reason_vld),
  .res_known(res_known), .proto_err(proto_err)
);

// File: tb/branch_addr_rebuild_tb.sv
`timescale 1ns/1ps
module branch_addr_rebuild_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        trace_start = 1'b0;
  logic        pkt_valid = 1'b0;
  logic        pkt_ready;
  logic [7:0]  pkt_data = '0;
  logic        res_valid;
  logic        res_ready = 1'b1;
  logic [31:0] res_addr;
  logic [2:0]  res_reason;
  logic        res_reason_vld;
  logic        res_known;
  logic        proto_err;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  branch_addr_rebuild dut_i (
    .clk(clk), .rst(rst), .trace_start(trace_start),
    .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_data(pkt_data),
    .res_valid(res_valid), .res_ready(res_ready), .res_addr(res_addr),
    .res_reason(res_reason), .res_reason_vld(res_reason_vld),
    .res_known(res_known), .proto_err(proto_err)
  );

  typedef struct packed {
    logic [39:0] bytes;
    logic [2:0]  cnt;
    logic [31:0] addr;
    logic [2:0]  reason;
    logic        rvld;
    logic        known;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{40'h00_00_00_2A_95, 3'd2, 32'h0000_1515, 3'd0, 1'b0, 1'b0},
    '{40'h5A_84_83_82_81, 3'd5, 32'hA080_C101, 3'd5, 1'b1, 1'b1},
    '{40'h00_00_00_00_7F, 3'd1, 32'hA080_C17F, 3'd0, 1'b0, 1'b1},
    '{40'h00_00_7F_80_80, 3'd3, 32'hA09F_C000, 3'd0, 1'b0, 1'b1},
    '{40'h00_01_FF_FF_FF, 3'd4, 32'hA03F_FFFF, 3'd0, 1'b0, 1'b1},
    '{40'h73_80_80_80_80, 3'd5, 32'h3000_0000, 3'd7, 1'b1, 1'b1}
  };

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic put(logic [7:0] b);
    pkt_valid = 1'b1;
    pkt_data  = b;
    @(negedge clk);
    pkt_valid = 1'b0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R10: reset state
    chk("R10 valid", {31'd0, res_valid}, 32'd0);
    chk("R10 addr", res_addr, 32'd0);
    chk("R10 known", {31'd0, res_known}, 32'd0);
    chk("R10 err", {31'd0, proto_err}, 32'd0);
    chk("R10 ready", {31'd0, pkt_ready}, 32'd1);

    // Table walk: R1 R2 R3 R4 R5 R7
    for (int v = 0; v < NV; v++) begin
      for (int i = 0; i < int'(VECS[v].cnt); i++) put(VECS[v].bytes[8*i +: 8]);
      chk("R7 strobe", {31'd0, res_valid}, 32'd1);
      chk("R1/R3 addr", res_addr, VECS[v].addr);
      chk("R4 reason", {29'd0, res_reason}, {29'd0, VECS[v].reason});
      chk("R4 reason_vld", {31'd0, res_reason_vld}, {31'd0, VECS[v].rvld});
      chk("R5 known", {31'd0, res_known}, {31'd0, VECS[v].known});
      @(negedge clk);
      chk("R7 strobe one cycle", {31'd0, res_valid}, 32'd0);
    end

    // R9: over-long sequence
    put(8'h81); put(8'h82); put(8'h83); put(8'h84); put(8'h85);
    chk("R9 err pulse", {31'd0, proto_err}, 32'd1);
    chk("R9 no result", {31'd0, res_valid}, 32'd0);
    @(negedge clk);
    chk("R9 err ends", {31'd0, proto_err}, 32'd0);
    put(8'h11);
    chk("R9 resync addr", res_addr, 32'h3000_0011);
    chk("R9 resync known", {31'd0, res_known}, 32'd1);
    @(negedge clk);

    // R8: back-pressure
    res_ready = 1'b0;
    put(8'h22);
    chk("R8 valid", {31'd0, res_valid}, 32'd1);
    chk("R8 ready low", {31'd0, pkt_ready}, 32'd0);
    pkt_valid = 1'b1;
    pkt_data  = 8'hB3;
    repeat (3) @(negedge clk);
    pkt_valid = 1'b0;
    chk("R8 held valid", {31'd0, res_valid}, 32'd1);
    chk("R8 held addr", res_addr, 32'h3000_0022);
    res_ready = 1'b1;
    @(negedge clk);
    chk("R8 released", {31'd0, res_valid}, 32'd0);
    put(8'h44);
    chk("R8 stalled byte ignored", res_addr, 32'h3000_0044);
    @(negedge clk);

    // R6: start-of-trace with a byte in the same cycle
    trace_start = 1'b1;
    pkt_valid = 1'b1;
    pkt_data  = 8'h85;
    @(negedge clk);
    trace_start = 1'b0;
    pkt_valid = 1'b0;
    chk("R6 known cleared", {31'd0, res_known}, 32'd0);
    chk("R6 no result", {31'd0, res_valid}, 32'd0);
    put(8'h06);
    chk("R6 addr cleared", res_addr, 32'h0000_0006);
    chk("R6 R5 still unknown", {31'd0, res_known}, 32'd0);
    @(negedge clk);

    // R6: start-of-trace mid-sequence
    put(8'h81); put(8'h82);
    trace_start = 1'b1;
    @(negedge clk);
    trace_start = 1'b0;
    put(8'h03);
    chk("R6 partial dropped", res_addr, 32'h0000_0003);
    @(negedge clk);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule